// File: doc/BRIEF.md
# ECAM Configuration Access Translator

This block sits in front of a memory-mapped configuration window of a PCIe root port. A configuration request arrives as a bus number, a device/function number and a register offset. The block checks whether the request may go out. If it may, the block turns it into a flat window offset and a full address, adding a programmable 64-bit window base. If it may not, the block issues no downstream access, drops a write, and completes a read with all ones.

The root bus number and the link-up status are live inputs. Only device/function 0 is reachable on the root bus. Any other bus is reachable only while the link is up. Offsets that are not 4-byte aligned are refused, and every request is refused while the unit is disabled.

A small register set holds the controls. It has a read-only capability word with a presence flag, a control word with an enable bit and a 5-bit size field that reads back as the last bus number, and two base-address halves. The decision is registered: the result appears exactly one clock after the request strobe.

A three-state machine carries each result:

- `ST_IDLE`: no result this cycle.
- `ST_ISSUE`: an access goes out.
- `ST_REJECT`: a refusal is reported.

On every clock the next state is chosen from the current request:

- no strobe: go to `ST_IDLE`;
- strobe and the request allowed: go to `ST_ISSUE`;
- strobe and the request refused: go to `ST_REJECT`.

The same transitions apply from all three states, so back-to-back requests are accepted.

Top module: `ecam_cfg_xlate`

## Requirements
- R1: After reset `acc_valid` and `rej_valid` are low, the control word (`reg_sel`=1) reads 32'h000C_0000 (enable clear, size 12), and the capability word (`reg_sel`=0) reads 32'h0000_0001.
- R2: An issued access carries `acc_offset` = bus<<20 | devfn<<12 | offset, and `acc_addr` = {base_hi, base_lo} + `acc_offset` with full 64-bit carry. Both appear one clock after the strobe.
- R3: On a request whose bus equals `root_bus`, any nonzero device/function number is rejected. Device/function 0 on the root bus is allowed whatever the value of `link_up`.
- R4: A request to any bus other than `root_bus` is rejected while `link_up` is 0, and allowed while it is 1.
- R5: While control bit 0 (enable) is clear, every request is rejected.
- R6: A request whose offset bits [1:0] are not zero is rejected.
- R7: A rejected read gives `rej_rdata` = 32'hFFFF_FFFF. A rejected write gives `rej_rdata` = 0 and raises neither `acc_valid` nor `acc_write`.
- R8: Control-word writes keep only bit 0 (enable) and bits 20:16 (size); the other bits read back as 0. The base halves (`reg_sel`=2 low, 3 high) read back exactly as written.
- R9: Each strobe produces exactly one of `acc_valid` or `rej_valid`, one clock later. No cycle without a strobe produces either.
- R10: `acc_write` is high only together with `acc_valid`. On an issued write, `acc_wdata` equals the request data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_offset | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| root_bus | input | 8 | Bus number of the root port |
| link_up | input | 1 | PCIe link-up status |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 caps, 1 control, 2 base low, 3 base high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| acc_valid | output | 1 | Downstream access issued |
| acc_write | output | 1 | Issued access is a write |
| acc_offset | output | 28 | Window byte offset |
| acc_addr | output | 64 | Base plus window offset |
| acc_wdata | output | 32 | Write data of the issued access |
| rej_valid | output | 1 | Request refused |
| rej_rdata | output | 32 | Completion data of a refused request |

## Verification
The bench targets the following corner cases and the failure each one would show:

- **Root-bus device numbers.** A translator that filtered device numbers on every bus would lose downstream devices. One that forgot the filter would reach phantom functions on the root port.
- **Root bus with the link down.** The check must not depend on the link there; a design that checked it would hide the root port itself.
- **Link drop on downstream buses.** Exactly at this point an unprotected design would issue accesses to an absent link.
- **Misaligned offsets, and writes versus reads on refusal.** A leaked write would show up as `acc_write` without a valid access. A wrong completion would return zeros instead of all ones.
- **Base carry.** A base whose low half is close to overflow exposes a translator that adds only 32 bits.
- **Timing.** Back-to-back strobes confirm the single-cycle timing and that no stale result lingers.

// File: rtl/ecam_xlate_pkg.sv
package ecam_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REJECT = 2'd2
    } xl_state_t;

    typedef enum logic [1:0] {
        RSEL_CAPS    = 2'd0,
        RSEL_CTRL    = 2'd1,
        RSEL_BASE_LO = 2'd2,
        RSEL_BASE_HI = 2'd3
    } rsel_t;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SIZE_LSB = 16;
    localparam int SIZE_W        = 5;

endpackage

// File: rtl/ecam_ctrl_regs.sv
module ecam_ctrl_regs
    import ecam_xlate_pkg::*;
#(
    parameter int REG_W        = 32,
    parameter int SIZE_DEFAULT = 12,
    parameter bit UNIT_PRESENT = 1'b1,
    localparam int ADDR_W      = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              en,
    output logic [ADDR_W-1:0] base
);
    logic              en_q;
    logic [SIZE_W-1:0] size_q;
    logic [REG_W-1:0]  base_lo_q, base_hi_q;
    logic [REG_W-1:0]  caps_word, ctrl_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            size_q    <= SIZE_W'(SIZE_DEFAULT);
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else if (wr) begin
            unique case (rsel_t'(sel))
                RSEL_CTRL: begin
                    en_q   <= wdata[CTRL_EN_BIT];
                    size_q <= wdata[CTRL_SIZE_LSB +: SIZE_W];
                end
                RSEL_BASE_LO: base_lo_q <= wdata;
                RSEL_BASE_HI: base_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        caps_word = '0;
        caps_word[0] = UNIT_PRESENT;
        ctrl_word = '0;
        ctrl_word[CTRL_EN_BIT] = en_q;
        ctrl_word[CTRL_SIZE_LSB +: SIZE_W] = size_q;
    end

    always_comb begin
        unique case (rsel_t'(sel))
            RSEL_CAPS:    rdata = caps_word;
            RSEL_CTRL:    rdata = ctrl_word;
            RSEL_BASE_LO: rdata = base_lo_q;
            RSEL_BASE_HI: rdata = base_hi_q;
            default:      rdata = '0;
        endcase
    end

    assign en   = en_q;
    assign base = {base_hi_q, base_lo_q};

endmodule

// File: rtl/ecam_req_check.sv
module ecam_req_check #(
    parameter int BUS_W      = 8,
    parameter int DEVFN_W    = 8,
    parameter int ALIGN_BITS = 2
) (
    input  logic               en,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [ALIGN_BITS-1:0] off_lo,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic               link_up,
    output logic               allow
);
    logic on_root;
    logic route_ok;
    logic aligned;

    assign on_root = (bus == root_bus);

    // Root port carries a single function; downstream needs a live link.
    assign route_ok = on_root ? (devfn == '0) : link_up;

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign aligned = (off_lo == '0);
        end else begin : g_noalign
            assign aligned = 1'b1;
        end
    endgenerate

    assign allow = en & aligned & route_ok;

endmodule

// File: rtl/ecam_addr_form.sv
module ecam_addr_form #(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int OFF_W   = 12,
    parameter int ADDR_W  = 64,
    localparam int WIN_W  = BUS_W + DEVFN_W + OFF_W
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFF_W-1:0]   off,
    input  logic [ADDR_W-1:0]  base,
    output logic [WIN_W-1:0]   win_off,
    output logic [ADDR_W-1:0]  addr
);
    // Fields are disjoint, so concatenation equals the shifted OR.
    assign win_off = {bus, devfn, off};
    assign addr    = base + ADDR_W'(win_off);

endmodule

// File: rtl/ecam_cfg_xlate.sv
module ecam_cfg_xlate
    import ecam_xlate_pkg::*;
#(
    parameter int BUS_W        = 8,
    parameter int DEVFN_W      = 8,
    parameter int OFF_W        = 12,
    parameter int REG_W        = 32,
    parameter int DATA_W       = 32,
    parameter int ALIGN_BITS   = 2,
    parameter int SIZE_DEFAULT = 12,
    parameter bit UNIT_PRESENT = 1'b1,
    localparam int ADDR_W      = 2 * REG_W,
    localparam int WIN_W       = BUS_W + DEVFN_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic               link_up,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               acc_valid,
    output logic               acc_write,
    output logic [WIN_W-1:0]   acc_offset,
    output logic [ADDR_W-1:0]  acc_addr,
    output logic [DATA_W-1:0]  acc_wdata,
    output logic               rej_valid,
    output logic [DATA_W-1:0]  rej_rdata
);
    logic              ctrl_en;
    logic [ADDR_W-1:0] win_base;
    logic              allow;
    logic [WIN_W-1:0]  win_d;
    logic [ADDR_W-1:0] addr_d;

    xl_state_t         state_q, state_d;
    logic [WIN_W-1:0]  win_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;

    ecam_ctrl_regs #(
        .REG_W(REG_W), .SIZE_DEFAULT(SIZE_DEFAULT), .UNIT_PRESENT(UNIT_PRESENT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .en(ctrl_en), .base(win_base)
    );

    ecam_req_check #(
        .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .ALIGN_BITS(ALIGN_BITS)
    ) u_check (
        .en(ctrl_en), .bus(req_bus), .devfn(req_devfn),
        .off_lo(req_offset[ALIGN_BITS-1:0]), .root_bus(root_bus),
        .link_up(link_up), .allow(allow)
    );

    ecam_addr_form #(
        .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
    ) u_form (
        .bus(req_bus), .devfn(req_devfn), .off(req_offset),
        .base(win_base), .win_off(win_d), .addr(addr_d)
    );

    // Next-state choice is the same from every state: one result per strobe.
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_ISSUE, ST_REJECT: begin
                if (!req_valid)  state_d = ST_IDLE;
                else if (allow)  state_d = ST_ISSUE;
                else             state_d = ST_REJECT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (req_valid) begin
            win_q   <= win_d;
            addr_q  <= addr_d;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    always_comb begin
        acc_valid  = 1'b0;
        acc_write  = 1'b0;
        rej_valid  = 1'b0;
        rej_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                acc_valid = 1'b1;
                acc_write = wr_q;
            end
            ST_REJECT: begin
                rej_valid = 1'b1;
                rej_rdata = wr_q ? '0 : '1;
            end
            default: ;
        endcase
    end

    assign acc_offset = win_q;
    assign acc_addr   = addr_q;
    assign acc_wdata  = wdata_q;

endmodule

// File: rtl/ecam_cfg_xlate_chk.sv
module ecam_cfg_xlate_chk #(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int OFF_W   = 12,
    parameter int DATA_W  = 32,
    localparam int WIN_W  = BUS_W + DEVFN_W + OFF_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [BUS_W-1:0]   req_bus,
    input logic [DEVFN_W-1:0] req_devfn,
    input logic [OFF_W-1:0]   req_offset,
    input logic [DATA_W-1:0]  req_wdata,
    input logic [BUS_W-1:0]   root_bus,
    input logic               link_up,
    input logic               ctrl_en,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [WIN_W-1:0]   acc_offset,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic               rej_valid,
    input logic [DATA_W-1:0]  rej_rdata
);
    a_r9_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && rej_valid));

    a_r9_result_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && rst_n) |-> (acc_valid || rej_valid));

    a_r9_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid && rst_n) |-> !(acc_valid || rej_valid));

    a_r2_offset_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(rst_n)) |-> acc_offset == $past({req_bus, req_devfn, req_offset}));

    a_r3_root_single_fn: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && rst_n && req_bus == root_bus && req_devfn != '0) |-> rej_valid);

    a_r4_link_down_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && rst_n && req_bus != root_bus && !link_up) |-> rej_valid);

    a_r5_disabled_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && rst_n && !ctrl_en) |-> rej_valid);

    a_r6_misaligned_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && rst_n && req_offset[1:0] != 2'b00) |-> rej_valid);

    a_r7_read_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_valid && $past(!req_write)) |-> rej_rdata == '1);

    a_r10_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        acc_write |-> acc_valid);

    a_r10_wdata_passed: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write && $past(rst_n)) |-> acc_wdata == $past(req_wdata));

endmodule

bind ecam_cfg_xlate ecam_cfg_xlate_chk #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .req_wdata(req_wdata), .root_bus(root_bus), .link_up(link_up),
    .ctrl_en(ctrl_en), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .rej_valid(rej_valid),
    .rej_rdata(rej_rdata)
);

// File: tb/sim_ecam_cfg_xlate.sv
module sim_ecam_cfg_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0, req_devfn = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  root_bus = '0;
    logic        link_up = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid, acc_write, rej_valid;
    logic [27:0] acc_offset;
    logic [63:0] acc_addr;
    logic [31:0] acc_wdata, rej_rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // model state
    bit          m_en = 1'b0;
    logic [63:0] m_base = '0;

    always #2 clk = ~clk;

    ecam_cfg_xlate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
        .req_wdata(req_wdata), .root_bus(root_bus), .link_up(link_up),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rej_valid(rej_valid), .rej_rdata(rej_rdata)
    );

    function automatic bit exp_allow(input logic [7:0] b, input logic [7:0] df,
                                     input logic [11:0] off);
        if (!m_en) return 1'b0;
        if (off[1:0] != 2'b00) return 1'b0;
        if (b == root_bus) return (df == 8'd0);
        return link_up;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    // Issue one request and check the result one clock later.
    task automatic do_req(input logic [7:0] b, input logic [7:0] df,
                          input logic [11:0] off, input bit wr,
                          input logic [31:0] wd, input string tag);
        bit ok;
        logic [27:0] eoff;
        ok   = exp_allow(b, df, off);
        eoff = {b, df, off};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bus = b; req_devfn = df;
        req_offset = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(acc_valid == ok && rej_valid == !ok, {tag, " R9 result"},
              {62'd0, acc_valid, rej_valid}, {62'd0, ok, !ok});
        if (ok) begin
            check(acc_offset == eoff, {tag, " R2 offset"}, 64'(acc_offset), 64'(eoff));
            check(acc_addr == m_base + 64'(eoff), {tag, " R2 addr"}, acc_addr,
                  m_base + 64'(eoff));
            check(acc_write == wr, {tag, " R10 write flag"}, 64'(acc_write), 64'(wr));
            if (wr) check(acc_wdata == wd, {tag, " R10 wdata"}, 64'(acc_wdata), 64'(wd));
        end else begin
            check(rej_rdata == (wr ? 32'h0 : 32'hFFFF_FFFF), {tag, " R7 rdata"},
                  64'(rej_rdata), wr ? 64'h0 : 64'hFFFF_FFFF);
            check(!acc_write, {tag, " R7 no write"}, 64'(acc_write), 64'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd2024));
        root_bus = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!acc_valid && !rej_valid, "R1 outputs idle",
              {62'd0, acc_valid, rej_valid}, 64'd0);
        reg_read(2'd1, rd);
        check(rd == 32'h000C_0000, "R1 control default", 64'(rd), 64'h000C_0000);
        reg_read(2'd0, rd);
        check(rd == 32'h1, "R1 capability", 64'(rd), 64'h1);

        // R5 disabled: even a clean root request is refused
        link_up = 1'b1;
        do_req(8'd0, 8'd0, 12'h010, 1'b0, 32'h0, "R5 disabled read");
        do_req(8'd1, 8'd0, 12'h000, 1'b1, 32'h1234, "R5 disabled write");

        // R8 register writes
        reg_write(2'd1, 32'hFF1F_FF0F);
        m_en = 1'b1;
        reg_read(2'd1, rd);
        check(rd == 32'h001F_0001, "R8 control mask", 64'(rd), 64'h001F_0001);
        reg_write(2'd2, 32'hFFF0_0000);
        reg_write(2'd3, 32'h0000_0001);
        m_base = 64'h0000_0001_FFF0_0000;
        reg_read(2'd2, rd);
        check(rd == 32'hFFF0_0000, "R8 base low", 64'(rd), 64'hFFF0_0000);
        reg_read(2'd3, rd);
        check(rd == 32'h1, "R8 base high", 64'(rd), 64'h1);

        // Directed corners
        do_req(8'd0, 8'd0, 12'hFFC, 1'b0, 32'h0, "R3 root fn0");
        do_req(8'd0, 8'd8, 12'h000, 1'b0, 32'h0, "R3 root fn8");
        do_req(8'd0, 8'd1, 12'h004, 1'b1, 32'hAAAA_5555, "R3 root fn1 write");
        do_req(8'd1, 8'd0, 12'h100, 1'b1, 32'hDEAD_BEEF, "R4 link up write");
        do_req(8'hFF, 8'hFF, 12'hFFC, 1'b0, 32'h0, "R2 carry corner");
        do_req(8'd2, 8'd0, 12'h002, 1'b0, 32'h0, "R6 misaligned");
        do_req(8'd0, 8'd0, 12'h001, 1'b1, 32'h5, "R6 misaligned root write");
        link_up = 1'b0;
        do_req(8'd1, 8'd0, 12'h000, 1'b0, 32'h0, "R4 link down read");
        do_req(8'd1, 8'd0, 12'h000, 1'b1, 32'h77, "R7 link down write");
        do_req(8'd0, 8'd0, 12'h008, 1'b0, 32'h0, "R3 root with link down");

        // Back-to-back strobes then a quiet cycle (R9)
        link_up = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd3; req_devfn = 8'd0;
        req_offset = 12'h040;
        @(negedge clk);
        check(acc_valid && !rej_valid, "R9 first of pair", 64'(acc_valid), 64'h1);
        req_bus = 8'd0; req_devfn = 8'd2;
        @(negedge clk);
        req_valid = 1'b0;
        check(rej_valid && !acc_valid, "R9 second of pair", 64'(rej_valid), 64'h1);
        @(negedge clk);
        check(!acc_valid && !rej_valid, "R9 quiet cycle",
              {62'd0, acc_valid, rej_valid}, 64'd0);

        // Random mix
        root_bus = 8'd4;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] b, df;
            logic [11:0] off;
            int pick;
            if (i % 50 == 25) link_up = ~link_up;
            pick = $urandom_range(0, 3);
            b  = (pick == 0) ? root_bus : (pick == 1) ? root_bus + 8'd1 : 8'($urandom);
            df = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom);
            off = 12'($urandom);
            if ($urandom_range(0, 3) != 0) off[1:0] = 2'b00;
            if (i == 200) begin
                reg_write(2'd1, 32'h000C_0000);
                m_en = 1'b0;
            end
            if (i == 260) begin
                reg_write(2'd1, 32'h000C_0001);
                m_en = 1'b1;
            end
            do_req(b, df, off, 1'($urandom), $urandom, "R2 random");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule